// File: doc/BRIEF.md
# Fractional-Dither Reload Down-Timer

This block is an 8-bit down-counter that reloads itself. Each time it passes zero it makes one underflow, and that underflow marks the end of a period of `reload_val + 1` count-clock cycles. The block can tune the average period in sixteenths of a cycle. It counts underflows in a repeating window of sixteen positions. A 4-bit fine setting picks some of those positions, and the period that follows each picked position gets one extra count-clock cycle. The extra cycle lengthens both the gap between underflow pulses and the half-period of the toggling output clock.

The counter decrements only on system-clock cycles in which `cnt_en` is high. `cnt_en` is the divided count clock, which comes from outside the block. `run` stops and restarts counting. `preset` reloads the counter and puts the window back at position 1. Every underflow sets a sticky interrupt flag. Software clears the flag by writing 1 to it. The flag is passed to the interrupt request only while the interrupt enable is set.

Top module: `fdither_timer`

## Requirements
- R1: When no delay applies, consecutive underflow pulses lie `reload_val + 1` enabled count cycles apart. `uf_pulse` is high for exactly one system clock per underflow. After `preset`, the first underflow comes after `reload_val + 1` enabled cycles.
- R2: `clk_out` inverts in the same clock in which `uf_pulse` goes high, and only then.
- R3: Fine setting N delays the period that follows underflow position p if and only if p is one of the first N entries of this order: 16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9. A delayed period is `reload_val + 2` enabled cycles long.
- R4: The position counter starts at 1, advances by one on each underflow, and wraps from 16 back to 1.
- R5: Fine setting 0 adds no delay. Position 1 is never delayed, whatever the setting.
- R6: The counter and any pending delay cycle advance only on cycles in which `cnt_en` is 1. With `cnt_en` high on alternate cycles, every interval is twice as long.
- R7: While `run` is 0, the counter and the position are frozen and no underflow occurs. Counting resumes from the frozen value.
- R8: `preset` loads `reload_val` into the counter, returns the position to 1 and cancels any pending delay. It takes priority over counting.
- R9: Each underflow sets `irq_flag`. `irq_req` is high exactly when `irq_flag` and `irq_en` are both 1.
- R10: A write (`flag_wr` = 1) with `flag_wdata` = 1 clears `irq_flag`. A write with data 0 leaves the flag unchanged. If an underflow and a clearing write fall in the same cycle, the flag stays set.
- R11: After reset, `uf_pulse`, `clk_out`, `irq_flag` and `irq_req` are 0, the fine setting takes effect only once driven, and the position is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-clock enable, one system clock per count tick |
| run | input | 1 | 1 = count, 0 = freeze |
| preset | input | 1 | Reload the counter and restart the position window |
| reload_val | input | 8 | Value loaded at each underflow and on preset |
| fine_sel | input | 4 | Number of delayed periods per 16 underflows |
| irq_en | input | 1 | Interrupt enable |
| flag_wr | input | 1 | Write strobe for the interrupt flag |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| uf_pulse | output | 1 | One-clock pulse per underflow |
| clk_out | output | 1 | Output clock, inverted at each underflow |
| irq_flag | output | 1 | Sticky underflow flag |
| irq_req | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
The hardest case to reach is a full window with several settings. In it, the delayed positions must fall at the right places and must survive the wrap from 16 to 1. The stimulus presets the timer for each vector and then records 33 underflows, so 32 intervals cover two full windows. Each interval is compared with a value computed from the priority order. One vector uses reload 0, where the counter sits at zero. A race between setting and clearing the flag cannot be timed from the ports with an ordinary reload. Reload 0 makes every enabled cycle an underflow, so any clearing write collides with a set.

// File: rtl/fdt_pkg.sv
`timescale 1ns/1ps
// fdt_pkg: shared helpers for the fractional-dither timer.
// Assumes the position window is a power of two long (2**FINE_W slots).
package fdt_pkg;

    // Reverse the bit order of a 4-bit value.
    function automatic logic [3:0] bitrev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    // slot_idx = position - 1. The period after position p is stretched
    // when the rank of p, bitrev((-p) mod 16), is below the fine setting.
    function automatic logic stretch_hit(input logic [3:0] slot_idx,
                                         input logic [3:0] fine);
        return bitrev4(~slot_idx) < fine;
    endfunction

endpackage

// File: rtl/fdt_dither.sv
`timescale 1ns/1ps
// fdt_dither: keeps the underflow position (slot 0..15 = positions 1..16)
// and says whether the period after the current underflow is stretched.
// Assumes uf_evt and preset are never high together (the counter ensures this).
module fdt_dither #(
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uf_evt,
    input  logic              preset,
    input  logic [FINE_W-1:0] fine_sel,
    output logic              stretch
);
    import fdt_pkg::*;

    localparam logic [FINE_W-1:0] LAST_SLOT = '1;

    logic [FINE_W-1:0] slot_q;

    // Position counter: cleared by preset, advanced by each underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot_q <= '0;
        else if (preset) slot_q <= '0;
        else if (uf_evt) slot_q <= slot_q + 1'b1;
    end

    // Stretch decision for the current position and fine setting.
    always_comb begin
        stretch = stretch_hit(slot_q, fine_sel);
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && !preset && slot_q == LAST_SLOT) |=> (slot_q == '0)); // R4
    AST_FIRST_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == '0) |-> !stretch); // R5
    AST_FINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_sel == '0) |-> !stretch); // R5
    AST_PRESET_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (slot_q == '0)); // R8
endmodule

// File: rtl/fdt_counter.sv
`timescale 1ns/1ps
// fdt_counter: reload down-counter with a one-cycle hold state for stretched
// periods, a registered underflow pulse and the toggling output clock.
// Assumes cnt_en is a one-clock enable per count tick.
module fdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             run,
    input  logic             preset,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             stretch,
    output logic             uf_evt,
    output logic             uf_pulse,
    output logic             clk_out
);
    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;
    logic             tick;

    // A count tick happens when the timer is running, enabled and not presetting.
    always_comb begin
        tick   = run && cnt_en && !preset;
        uf_evt = tick && !hold_q && (cnt_q == '0);
    end

    // Counter and pending-hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else if (preset) begin
            cnt_q  <= reload_val;
            hold_q <= 1'b0;
        end else if (tick) begin
            if (hold_q) begin
                hold_q <= 1'b0;
            end else if (cnt_q == '0) begin
                cnt_q  <= reload_val;
                hold_q <= stretch;
            end else begin
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    // Registered underflow pulse and output clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_pulse <= 1'b0;
            clk_out  <= 1'b0;
        end else begin
            uf_pulse <= uf_evt;
            if (uf_evt) clk_out <= ~clk_out;
        end
    end

    AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (cnt_q == $past(reload_val))); // R1
    AST_TOGGLE_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (uf_pulse && clk_out != $past(clk_out))); // R2
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && tick) |=> (cnt_q == $past(cnt_q) && !hold_q)); // R3
    AST_NO_EN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !preset) |=> ($stable(cnt_q) && !uf_pulse)); // R6
    AST_STOP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !preset) |=> ($stable(cnt_q) && $stable(clk_out))); // R7
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (cnt_q == $past(reload_val) && !hold_q)); // R8
endmodule

// File: rtl/fdt_irq.sv
`timescale 1ns/1ps
// fdt_irq: sticky underflow flag with write-1-to-clear and the gated request.
// Assumes a set and a clear in the same cycle resolve as a set.
module fdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_evt,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic irq_en,
    output logic irq_flag,
    output logic irq_req
);
    // Flag update: a hardware set outranks a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_flag <= 1'b0;
        else if (uf_evt)                  irq_flag <= 1'b1;
        else if (flag_wr && flag_wdata)   irq_flag <= 1'b0;
    end

    // Request gating by the enable.
    always_comb begin
        irq_req = irq_flag && irq_en;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> irq_flag); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata && !uf_evt) |=> !irq_flag); // R10
    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata && !uf_evt) |=> $stable(irq_flag)); // R10
endmodule

// File: rtl/fdither_timer.sv
`timescale 1ns/1ps
// fdither_timer: top of the fractional-dither reload down-timer. Wires the
// counter, the position/dither logic and the interrupt flag together.
// Assumes all inputs are synchronous to clk.
module fdither_timer #(
    parameter int CNT_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              run,
    input  logic              preset,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [FINE_W-1:0] fine_sel,
    input  logic              irq_en,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic              uf_pulse,
    output logic              clk_out,
    output logic              irq_flag,
    output logic              irq_req
);
    logic uf_evt;
    logic stretch;

    fdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .run        (run),
        .preset     (preset),
        .reload_val (reload_val),
        .stretch    (stretch),
        .uf_evt     (uf_evt),
        .uf_pulse   (uf_pulse),
        .clk_out    (clk_out)
    );

    fdt_dither #(.FINE_W(FINE_W)) u_dith (
        .clk      (clk),
        .rst_n    (rst_n),
        .uf_evt   (uf_evt),
        .preset   (preset),
        .fine_sel (fine_sel),
        .stretch  (stretch)
    );

    fdt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .uf_evt     (uf_evt),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .irq_en     (irq_en),
        .irq_flag   (irq_flag),
        .irq_req    (irq_req)
    );

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_en && irq_flag)); // R9
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |-> irq_flag || $past(flag_wr)); // R9
endmodule

// File: tb/fdither_timer_test.sv
`timescale 1ns/1ps
module fdither_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0, run = 1'b0, preset = 1'b0;
    logic [7:0] reload_val = '0;
    logic [3:0] fine_sel = '0;
    logic irq_en = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
    logic uf_pulse, clk_out, irq_flag, irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    fdither_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run), .preset(preset),
        .reload_val(reload_val), .fine_sel(fine_sel), .irq_en(irq_en),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .uf_pulse(uf_pulse),
        .clk_out(clk_out), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // Priority order of delayed positions (R3).
    localparam int ORD [15] = '{16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9};

    // Vectors: {fine[3:0], reload[7:0], divider[1:0]}.
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {4'd0,  8'd3, 2'd1}, {4'd1,  8'd2, 2'd1}, {4'd5,  8'd4, 2'd1},
        {4'd8,  8'd1, 2'd1}, {4'd15, 8'd0, 2'd1}, {4'd10, 8'd6, 2'd2},
        {4'd3,  8'd0, 2'd1}, {4'd12, 8'd2, 2'd2}
    };

    function automatic int delayed(int p, int n);
        for (int i = 0; i < n; i++) if (ORD[i] == p) return 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // Preset the timer, run it and check 32 intervals (R1 R3 R4 R5 R6 R8 R2).
    task automatic run_vec(int fine, int rl, int div);
        int cyc = 0, last = 0, nuf = 0, tog_bad = 0, guard = 0;
        logic prev_clk;
        @(negedge clk);
        preset = 1'b1; run = 1'b0; cnt_en = 1'b0;
        fine_sel = fine[3:0]; reload_val = rl[7:0];
        @(negedge clk);
        preset = 1'b0; run = 1'b1; cnt_en = 1'b1;
        prev_clk = clk_out;
        while (nuf < 33 && guard < 4000) begin
            @(negedge clk);
            cyc++; guard++;
            if (uf_pulse) begin
                nuf++;
                if (clk_out == prev_clk) tog_bad++;
                prev_clk = clk_out;
                if (nuf == 1) begin
                    if (div == 1) check("R1/R8 first underflow latency", cyc, rl + 1);
                end else begin
                    int p = ((nuf - 2) % 16) + 1;
                    check("R3/R4/R6 interval", cyc - last,
                          div * (rl + 1 + delayed(p, fine)));
                end
                last = cyc;
            end else if (clk_out != prev_clk) begin
                tog_bad++;
            end
            if (div == 2) cnt_en = ~cnt_en;
        end
        check("R2 clk_out toggles only on underflow", tog_bad, 0);
        check("R1 underflow count", nuf, 33);
        run = 1'b0; cnt_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 uf_pulse at reset", uf_pulse, 0);
        check("R11 clk_out at reset", clk_out, 0);
        check("R11 irq_flag at reset", irq_flag, 0);
        check("R11 irq_req at reset", irq_req, 0);

        // Table walk
        for (int v = 0; v < NV; v++)
            run_vec(int'(VEC[v][13:10]), int'(VEC[v][9:2]), int'(VEC[v][1:0]));

        // R9 flag set by underflows, request gated by enable
        @(negedge clk);
        check("R9 flag set after underflows", irq_flag, 1);
        check("R9 request blocked by enable 0", irq_req, 0);
        irq_en = 1'b1;
        #1;
        check("R9 request with enable 1", irq_req, 1);

        // R10 write 0 has no effect, write 1 clears
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0;
        check("R10 write 0 keeps flag", irq_flag, 1);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R10 write 1 clears flag", irq_flag, 0);
        check("R9 request drops with flag", irq_req, 0);

        // R10 set wins: reload 0 gives an underflow on every enabled cycle
        preset = 1'b1; reload_val = 8'd0; fine_sel = 4'd0;
        @(negedge clk);
        preset = 1'b0; run = 1'b1; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R10 set beats clear", irq_flag, 1);
        run = 1'b0;
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R10 clear while stopped", irq_flag, 0);

        // R7 stop freezes the counter
        begin
            int cyc = 0, bad = 0;
            logic held;
            preset = 1'b1; reload_val = 8'd5;
            @(negedge clk);
            preset = 1'b0; run = 1'b1; cnt_en = 1'b1;
            while (!uf_pulse && cyc < 100) begin @(negedge clk); cyc++; end
            run = 1'b0;
            held = clk_out;
            cyc = 0;
            repeat (10) begin
                @(negedge clk);
                cyc++;
                if (uf_pulse || clk_out != held) bad++;
            end
            check("R7 no underflow while stopped", bad, 0);
            run = 1'b1;
            while (!uf_pulse && cyc < 100) begin @(negedge clk); cyc++; end
            check("R7 resume from frozen count", cyc, 16);
            run = 1'b0; cnt_en = 1'b0;
        end

        finish_run();
    end
endmodule